// File: doc/BRIEF.md
# Scoped Write-Combining L1 Data Cache

This block is the private data cache of one compute unit. Stores finish inside the cache without first asking anyone for ownership of the line. Every line records, byte by byte, what was written locally, and only those bytes ever travel to the shared next level. There is no coherence protocol. Visibility is managed instead by the scope tag that rides on each release, acquire and atomic request.

Requests at sub-group or work-group scope stay local, because every thread that can observe them already shares this cache. A release or acquire at device or system scope walks the whole cache. It writes back every dirty line, whichever work-item dirtied it, and an acquire then also drops every line. Atomic fetch-and-add at narrow scope runs in the cache. At wide scope it is handed whole to the next level, after the cache has pushed out and dropped its own copy of the line. The core side takes one request at a time through a valid/ready handshake and answers each request with a one-cycle response pulse. The memory side moves whole 16-byte lines, or one word for an atomic.

Top module: `scoped_wc_l1`

## Requirements
- R1: A store that misses allocates the line without any read on the memory port. Core ops are 0 load, 1 store, 2 release, 3 acquire and 4 fetch-and-add. Memory ops are 0 line read, 1 byte-enabled line write and 2 word add.
- R2: Stores write only the bytes selected by core_be (bit i selects byte i of the word). A later load returns those bytes together with the unwritten ones. A load of a word whose four bytes were all written locally is served without a fill.
- R3: When a dirty line must leave to make room for another tag, one line write is issued. Its byte enables equal the line's dirty mask (bit 4*w+b for byte b of word w) and its address is the old line's word address. Clean bytes of that line in memory are left untouched.
- R4: A release with scope 2 (device) or 3 (system) writes back every dirty line in the cache before it is acknowledged. A second wide release with nothing dirty issues no writes. Scope encoding: 0 sub-group, 1 work-group, 2 device, 3 system.
- R5: An acquire with scope 2 or 3 first writes back dirty lines and then invalidates all lines, so the next load of any address reads the next level again.
- R6: Release and acquire with scope 0 or 1 are acknowledged with no memory traffic, and the cache contents stay usable: a following load hits with no read.
- R7: Fetch-and-add with scope 0 or 1 returns the old word, stores old plus operand in the cache and issues no memory request.
- R8: Fetch-and-add with scope 2 or 3 writes back the line's dirty bytes, drops the local line and issues a word add carrying the word address and the operand. It returns the old value that memory answers, and a later load refetches the line.
- R9: A load miss on a line that holds locally written bytes fetches the line and keeps the local bytes over the fetched ones.
- R10: After reset core_ready is 1 and no request or response is active. While a flush is stalled on the memory port, core_ready stays 0 and no acknowledgment is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_valid | input | 1 | Core request valid |
| core_ready | output | 1 | Cache can accept a request |
| core_op | input | 3 | Request kind |
| core_scope | input | 2 | Request scope |
| core_addr | input | AW | Word address |
| core_wdata | input | 32 | Store data or add operand |
| core_be | input | 4 | Store byte enables |
| core_resp_valid | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Load or atomic result |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_op | output | 2 | Memory request kind |
| mem_req_addr | output | AW | Word address (line aligned for line ops) |
| mem_req_wdata | output | 128 | Line data, or operand in low word |
| mem_req_be | output | 16 | Byte enables of a line write |
| mem_resp_valid | input | 1 | Memory response valid |
| mem_resp_data | input | 128 | Line data, or old word in low word |

## Verification
The bench goes after partially written lines. Without the mask merge on a fill, a load after a byte store would lose the local bytes. A cache that wrote whole lines would overwrite memory bytes that were never touched locally. It issues two wide releases in a row: a walk that ignores dirty bits would repeat the writes, and a walk that stops early would leave lines belonging to another work-item unwritten. Memory is changed behind the cache before a wide acquire, to expose stale data that survives invalidation. A forwarded atomic is issued on a dirty line, which catches the case where the local store is lost or the old copy is kept. A stalled memory port checks that the release acknowledgment waits.

// File: rtl/scoped_wc_l1.sv
module scoped_wc_l1 #(
  parameter int AW    = 12,
  parameter int LINES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         core_valid,
  output logic         core_ready,
  input  logic [2:0]   core_op,
  input  logic [1:0]   core_scope,
  input  logic [AW-1:0] core_addr,
  input  logic [31:0]  core_wdata,
  input  logic [3:0]   core_be,
  output logic         core_resp_valid,
  output logic [31:0]  core_rdata,
  output logic         mem_req_valid,
  input  logic         mem_req_ready,
  output logic [1:0]   mem_req_op,
  output logic [AW-1:0] mem_req_addr,
  output logic [127:0] mem_req_wdata,
  output logic [15:0]  mem_req_be,
  input  logic         mem_resp_valid,
  input  logic [127:0] mem_resp_data
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW - 2;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_REL = 3'd2, OP_ACQ = 3'd3, OP_ADD = 3'd4;
  localparam logic [1:0] M_RD = 2'd0, M_WR = 2'd1, M_ADD = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_WB, S_FILL, S_FWD, S_FLUSH} st_t;
  st_t st;

  logic [2:0]    r_op;
  logic [1:0]    r_scope;
  logic [AW-1:0] r_addr;
  logic [31:0]   r_wdata;
  logic [3:0]    r_be;
  logic          sent;
  logic [IW-1:0] cnt;

  logic [TW-1:0]  tag_q [LINES];
  logic [127:0]   dat_q [LINES];
  logic [15:0]    dty_q [LINES];
  logic [LINES-1:0] vld_q, fil_q;

  function automatic logic [31:0] bmask(input logic [3:0] b);
    for (int i = 0; i < 4; i++) bmask[i*8 +: 8] = {8{b[i]}};
  endfunction
  function automatic logic [127:0] lmask(input logic [15:0] b);
    for (int i = 0; i < 16; i++) lmask[i*8 +: 8] = {8{b[i]}};
  endfunction

  wire [IW-1:0] idx  = r_addr[IW+1:2];
  wire [TW-1:0] tg   = r_addr[AW-1:IW+2];
  wire [1:0]    wo   = r_addr[1:0];
  wire          wide = r_scope[1];
  wire          hit  = vld_q[idx] && (tag_q[idx] == tg);
  wire [3:0]    wd   = dty_q[idx][{wo, 2'b00} +: 4];
  wire          word_ok  = hit && (fil_q[idx] || &wd);
  wire          victim   = vld_q[idx] && !hit && (|dty_q[idx]);
  wire [31:0]   cur_word = dat_q[idx][{wo, 5'b0} +: 32];
  wire [31:0]   bm       = bmask(r_be);
  wire          fl_dirty = vld_q[cnt] && (|dty_q[cnt]);
  wire [IW-1:0] wb_line  = (st == S_FLUSH) ? cnt : idx;
  wire          fl_step  = !fl_dirty || mem_req_ready;

  assign core_ready    = (st == S_IDLE);
  assign mem_req_valid = (st == S_WB) || (st == S_FLUSH && fl_dirty) ||
                         ((st == S_FILL || st == S_FWD) && !sent);
  assign mem_req_op    = (st == S_FILL) ? M_RD : (st == S_FWD) ? M_ADD : M_WR;
  assign mem_req_addr  = (st == S_FWD)  ? r_addr :
                         (st == S_FILL) ? {tg, idx, 2'b00} : {tag_q[wb_line], wb_line, 2'b00};
  assign mem_req_wdata = (st == S_FWD) ? {96'b0, r_wdata} : dat_q[wb_line];
  assign mem_req_be    = (st == S_FWD || st == S_FILL) ? 16'h0 : dty_q[wb_line];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      core_resp_valid <= 1'b0;
      core_rdata <= '0;
      sent <= 1'b0;
      cnt <= '0;
      vld_q <= '0;
      fil_q <= '0;
      r_op <= '0; r_scope <= '0; r_addr <= '0; r_wdata <= '0; r_be <= '0;
      for (int i = 0; i < LINES; i++) dty_q[i] <= '0;
    end else begin
      core_resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (core_valid) begin
          r_op <= core_op; r_scope <= core_scope; r_addr <= core_addr;
          r_wdata <= core_wdata; r_be <= core_be;
          st <= S_RUN;
        end
        S_RUN: begin
          if (r_op == OP_ADD && wide) begin
            if (hit && |dty_q[idx]) st <= S_WB;
            else if (hit) begin vld_q[idx] <= 1'b0; fil_q[idx] <= 1'b0; end
            else begin st <= S_FWD; sent <= 1'b0; end
          end else if (r_op == OP_LD || r_op == OP_ADD) begin
            if (word_ok) begin
              core_rdata <= cur_word;
              core_resp_valid <= 1'b1;
              st <= S_IDLE;
              if (r_op == OP_ADD) begin
                dat_q[idx][{wo, 5'b0} +: 32] <= cur_word + r_wdata;
                dty_q[idx][{wo, 2'b00} +: 4] <= 4'hF;
              end
            end else if (victim) st <= S_WB;
            else begin st <= S_FILL; sent <= 1'b0; end
          end else if (r_op == OP_ST) begin
            if (hit) begin
              dat_q[idx][{wo, 5'b0} +: 32] <= (cur_word & ~bm) | (r_wdata & bm);
              dty_q[idx][{wo, 2'b00} +: 4] <= wd | r_be;
              core_resp_valid <= 1'b1;
              st <= S_IDLE;
            end else if (victim) st <= S_WB;
            else begin tag_q[idx] <= tg; vld_q[idx] <= 1'b1; fil_q[idx] <= 1'b0; end
          end else if ((r_op == OP_REL || r_op == OP_ACQ) && wide) begin
            cnt <= '0;
            st <= S_FLUSH;
          end else begin
            core_resp_valid <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_WB: if (mem_req_ready) begin
          dty_q[idx] <= '0;
          st <= S_RUN;
        end
        S_FILL: begin
          if (mem_req_ready && !sent) sent <= 1'b1;
          if (mem_resp_valid) begin
            dat_q[idx] <= (mem_resp_data & ~lmask(dty_q[idx])) | (dat_q[idx] & lmask(dty_q[idx]));
            tag_q[idx] <= tg; vld_q[idx] <= 1'b1; fil_q[idx] <= 1'b1;
            st <= S_RUN;
          end
        end
        S_FWD: begin
          if (mem_req_ready && !sent) sent <= 1'b1;
          if (mem_resp_valid) begin
            core_rdata <= mem_resp_data[31:0];
            core_resp_valid <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_FLUSH: if (fl_step) begin
          if (fl_dirty) dty_q[cnt] <= '0;
          if (cnt == IW'(LINES - 1)) begin
            if (r_op == OP_ACQ) begin vld_q <= '0; fil_q <= '0; end
            core_resp_valid <= 1'b1;
            st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic any_dirty;
  always_comb begin
    any_dirty = 1'b0;
    for (int i = 0; i < LINES; i++) any_dirty = any_dirty | (|dty_q[i]);
  end

  AST_NO_WRITE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == M_RD) |-> (r_op != OP_ST)); // R1
  AST_WB_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == M_WR) |-> (mem_req_be != 16'h0)); // R3
  AST_REL_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (core_resp_valid && r_op == OP_REL && r_scope[1]) |-> !any_dirty); // R4
  AST_ACQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (core_resp_valid && r_op == OP_ACQ && r_scope[1]) |-> (vld_q == '0)); // R5
  AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !((r_op == OP_REL || r_op == OP_ACQ) && !r_scope[1])); // R6
  AST_ADD_WIDE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == M_ADD) |-> r_scope[1]); // R7
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> !core_resp_valid); // R10
endmodule

// File: tb/test_scoped_wc_l1.sv
`timescale 1ns/1ps
module test_scoped_wc_l1;
  localparam int AW = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic core_valid = 1'b0, core_ready;
  logic [2:0] core_op = '0;
  logic [1:0] core_scope = '0;
  logic [AW-1:0] core_addr = '0;
  logic [31:0] core_wdata = '0;
  logic [3:0] core_be = '0;
  logic core_resp_valid;
  logic [31:0] core_rdata;
  logic mem_req_valid, mem_req_ready;
  logic [1:0] mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [127:0] mem_req_wdata, mem_resp_data;
  logic [15:0] mem_req_be;
  logic mem_resp_valid;

  int checks = 0, errors = 0;
  int rd_n = 0, wr_n = 0, at_n = 0;
  logic [15:0] last_be;
  logic [AW-1:0] last_addr;
  logic mem_rdy = 1'b1;
  logic [127:0] mem [1024];
  logic [31:0] rv;

  always #2 clk = ~clk;
  assign mem_req_ready = mem_rdy;

  scoped_wc_l1 #(.AW(AW), .LINES(8)) i_scoped_wc_l1 (
    .clk(clk), .rst_n(rst_n), .core_valid(core_valid), .core_ready(core_ready),
    .core_op(core_op), .core_scope(core_scope), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_be(core_be), .core_resp_valid(core_resp_valid),
    .core_rdata(core_rdata), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_be(mem_req_be), .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data));

  always @(posedge clk) begin
    mem_resp_valid <= 1'b0;
    if (mem_req_valid && mem_rdy) begin
      case (mem_req_op)
        2'd0: begin rd_n++; mem_resp_data <= mem[mem_req_addr[AW-1:2]]; mem_resp_valid <= 1'b1; end
        2'd1: begin
          wr_n++; last_be = mem_req_be; last_addr = mem_req_addr;
          for (int b = 0; b < 16; b++)
            if (mem_req_be[b]) mem[mem_req_addr[AW-1:2]][b*8 +: 8] = mem_req_wdata[b*8 +: 8];
        end
        default: begin
          at_n++;
          mem_resp_data <= {96'b0, mem[mem_req_addr[AW-1:2]][mem_req_addr[1:0]*32 +: 32]};
          mem_resp_valid <= 1'b1;
          mem[mem_req_addr[AW-1:2]][mem_req_addr[1:0]*32 +: 32] =
            mem[mem_req_addr[AW-1:2]][mem_req_addr[1:0]*32 +: 32] + mem_req_wdata[31:0];
        end
      endcase
    end
  end

  task automatic chk(input logic ok, input string what, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s got %h exp %h", what, got, exp); end
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] sc, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    while (!core_ready) @(negedge clk);
    core_valid = 1'b1; core_op = op; core_scope = sc; core_addr = a; core_wdata = d; core_be = be;
    @(negedge clk);
    core_valid = 1'b0;
  endtask

  task automatic wait_resp(output logic [31:0] r);
    int n = 0;
    while (!core_resp_valid && n < 2000) begin @(negedge clk); n++; end
    if (!core_resp_valid) chk(1'b0, "R10 response timeout", 0, 1);
    r = core_rdata;
  endtask

  task automatic op(input logic [2:0] o, input logic [1:0] sc, input logic [AW-1:0] a,
                    input logic [31:0] d, input logic [3:0] be, output logic [31:0] r);
    issue(o, sc, a, d, be);
    wait_resp(r);
  endtask

  // {op, scope, addr, wdata, be, expected rdata}
  localparam logic [84:0] VEC [7] = '{
    {3'd0, 2'd0, 12'h010, 32'h0,        4'h0, 32'h50000010},
    {3'd1, 2'd0, 12'h011, 32'h11223344, 4'h3, 32'h0},
    {3'd0, 2'd0, 12'h011, 32'h0,        4'h0, 32'h50003344},
    {3'd4, 2'd1, 12'h012, 32'h5,        4'h0, 32'h50000012},
    {3'd0, 2'd1, 12'h012, 32'h0,        4'h0, 32'h50000017},
    {3'd1, 2'd0, 12'h025, 32'hAABBCCDD, 4'hF, 32'h0},
    {3'd0, 2'd0, 12'h025, 32'h0,        4'h0, 32'hAABBCCDD}
  };

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL R10 watchdog expired got 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r0, w0, a0;
    for (int i = 0; i < 1024; i++)
      for (int w = 0; w < 4; w++) mem[i][w*32 +: 32] = 32'h50000000 | 32'({i[9:0], w[1:0]});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(core_ready && !mem_req_valid && !core_resp_valid, "R10 reset state",
        {core_ready, mem_req_valid, core_resp_valid}, 3'b100);

    for (int v = 0; v < 7; v++) begin
      op(VEC[v][84:82], VEC[v][81:80], VEC[v][79:68], VEC[v][67:36], VEC[v][35:32], rv);
      if (VEC[v][84:82] != 3'd1) chk(rv == VEC[v][31:0], $sformatf("R2 R7 R9 vector %0d", v), rv, VEC[v][31:0]);
    end
    chk(at_n == 0, "R7 local atomic stayed local", at_n, 0);

    r0 = rd_n; w0 = wr_n;
    op(3'd1, 2'd0, 12'h0A8, 32'h0A0B0C0D, 4'hF, rv);
    chk(rd_n == r0 && wr_n == w0, "R1 store miss traffic", rd_n + wr_n, r0 + w0);

    op(3'd1, 2'd0, 12'h045, 32'h00EE0000, 4'h4, rv);
    chk(wr_n == w0 + 1, "R3 eviction count", wr_n, w0 + 1);
    chk(last_be == 16'h00F0 && last_addr == 12'h024, "R3 eviction mask/addr", {last_be, last_addr}, {16'h00F0, 12'h024});
    chk(mem[9][63:32] == 32'hAABBCCDD && mem[9][31:0] == 32'h50000024, "R3 eviction data", mem[9][63:0], {32'hAABBCCDD, 32'h50000024});

    r0 = rd_n;
    op(3'd0, 2'd0, 12'h045, 0, 0, rv);
    chk(rv == 32'h50EE0045 && rd_n == r0 + 1, "R9 fill merge", rv, 32'h50EE0045);

    r0 = rd_n; w0 = wr_n;
    op(3'd2, 2'd1, 12'h000, 0, 0, rv);
    op(3'd3, 2'd0, 12'h000, 0, 0, rv);
    op(3'd0, 2'd0, 12'h045, 0, 0, rv);
    chk(rd_n == r0 && wr_n == w0 && rv == 32'h50EE0045, "R6 narrow sync local", rv, 32'h50EE0045);

    w0 = wr_n;
    op(3'd2, 2'd2, 12'h000, 0, 0, rv);
    chk(wr_n == w0 + 3, "R4 release writes", wr_n, w0 + 3);
    chk(mem[4][63:32] == 32'h50003344 && mem[4][95:64] == 32'h50000017, "R4 line 4 data", mem[4], 0);
    chk(mem[17][63:32] == 32'h50EE0045 && mem[42][31:0] == 32'h0A0B0C0D, "R4 other lines", {mem[17][63:32], mem[42][31:0]}, {32'h50EE0045, 32'h0A0B0C0D});
    w0 = wr_n;
    op(3'd2, 2'd3, 12'h000, 0, 0, rv);
    chk(wr_n == w0, "R4 clean release no writes", wr_n, w0);

    op(3'd1, 2'd0, 12'h010, 32'h01020304, 4'hF, rv);
    mem[17][63:32] = 32'hDEADBEEF;
    w0 = wr_n; r0 = rd_n;
    op(3'd3, 2'd3, 12'h000, 0, 0, rv);
    chk(wr_n == w0 + 1 && mem[4][31:0] == 32'h01020304, "R5 acquire writeback", mem[4][31:0], 32'h01020304);
    op(3'd0, 2'd0, 12'h045, 0, 0, rv);
    chk(rv == 32'hDEADBEEF && rd_n == r0 + 1, "R5 refetch after acquire", rv, 32'hDEADBEEF);

    op(3'd1, 2'd0, 12'h030, 32'd7, 4'hF, rv);
    w0 = wr_n; a0 = at_n;
    op(3'd4, 2'd2, 12'h030, 32'd3, 4'h0, rv);
    chk(rv == 32'd7 && at_n == a0 + 1 && wr_n == w0 + 1, "R8 forwarded atomic", rv, 7);
    chk(mem[12][31:0] == 32'd10, "R8 memory updated", mem[12][31:0], 10);
    op(3'd0, 2'd0, 12'h030, 0, 0, rv);
    chk(rv == 32'd10, "R8 local copy dropped", rv, 10);

    op(3'd1, 2'd0, 12'h031, 32'h55, 4'hF, rv);
    mem_rdy = 1'b0;
    issue(3'd2, 2'd3, 12'h000, 0, 0);
    repeat (6) @(negedge clk);
    chk(!core_ready && !core_resp_valid && mem_req_valid, "R10 stalled flush holds",
        {core_ready, core_resp_valid, mem_req_valid}, 3'b001);
    mem_rdy = 1'b1;
    wait_resp(rv);
    chk(mem[12][63:32] == 32'h55, "R4 ack after stalled write", mem[12][63:32], 32'h55);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule